// File: doc/BRIEF.md
# Set-Associative Tag/Data Store with Age-Rank Replacement

This block is a small set-associative store. Each set holds a fixed number of ways, and each way keeps a valid flag, a tag, a data word and an age rank that is log2(ways) bits wide. A rank of 0 marks the most recently used way. A requester issues one operation at a time. The operation carries a set index, a tag, write data and a read/write select. One cycle after the request is accepted, a registered response returns the hit flag and the data.

A lookup compares the tag with every valid way of the selected set.

- **Lookup hit.** The response returns the stored word. The ranks are then rewritten in one extra cycle.
- **Lookup miss.** The response returns zero data and no rank changes.

A write first searches the set for its tag.

- **Write hit.** The way's data is overwritten in place. For rank purposes this counts as a hit.
- **Write miss, free way available.** The new entry goes into the lowest-index invalid way with rank 0. Every other valid way ages by one.
- **Write miss, set full.** A comparator tree selects the way with the largest rank as the victim. On equal ranks the lower way index wins. The new entry takes rank 0, and every way younger than the victim ages by one.

The controller has two states:

- **IDLE.** Requests are accepted here.
- **AGE_UPDATE.** This state lasts one cycle and rewrites the ranks after a hit. `busy` is high during it, and a request presented then is stalled until the next cycle.

Transitions:

- IDLE to AGE_UPDATE on an accepted request that hits.
- AGE_UPDATE to IDLE unconditionally.
- IDLE to IDLE on no request or on an accepted miss.

The way count must be a power of two.

Top module: `sa_age_cache`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every valid flag and rank. The cycle after reset, `busy` and `rsp_valid` are low. Every lookup after reset misses until a write fills the entry.
- R2: A request is accepted at a rising edge where `req_valid` is high and `busy` is low. In the following cycle, `rsp_valid` is high for exactly one cycle. On a lookup hit, `rsp_hit` is 1 and `rsp_data` is the stored word. On a lookup miss, `rsp_hit` is 0 and `rsp_data` is 0.
- R3: An accepted request that hits (lookup or write) moves the controller to AGE_UPDATE. `busy` is therefore high in the same cycle as its response and low in the cycle after. A miss never raises `busy`.
- R4: A write whose tag is absent from a set with an invalid way fills that way. Its response has `rsp_hit` 0 and echoes the write data on `rsp_data`. The entry is afterwards found by a lookup.
- R5: A write whose tag matches a valid way replaces that way's data without allocating a second entry. Its response has `rsp_hit` 1 and echoes the write data.
- R6: A write miss to a full set evicts the way with the largest rank, which is the least recently used way, with ties going to the lower way index. The evicted tag then misses and the other tags still hit.
- R7: A hit sets the hit way's rank to 0. It increments only the valid ways whose rank was below the hit way's old rank, saturating at ways-1. Valid ranks therefore stay distinct.
- R8: A lookup miss changes no rank, so a later eviction chooses the same victim it would have chosen without the miss.
- R9: A request presented while `busy` is high is not accepted and produces no response in the next cycle. If it is held, it is accepted at the following edge.
- R10: Operations on one set do not change the contents of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = lookup |
| req_set | input | $clog2(SETS) | Set index |
| req_tag | input | TAG_W | Tag to compare or store |
| req_wdata | input | DATA_W | Data for a write |
| busy | output | 1 | High during AGE_UPDATE; requests stall |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_hit | output | 1 | Tag matched a valid way |
| rsp_data | output | DATA_W | Read data, write data echo, or 0 on lookup miss |

## Verification
The bench drives inputs on the falling edge. A request is therefore accepted at the next rising edge, and its `rsp_valid`, `rsp_hit` and `rsp_data` are sampled at the falling edge after that, one cycle later. `busy` is sampled at the same falling edge, because AGE_UPDATE is entered at the edge that registers the response. Replacement order is never read directly. It is inferred from which tags miss after later evictions, each of which shows up in the response cycle of a subsequent lookup. Before each new request the bench waits out any busy cycle. For the stall case it samples one cycle into the stall, to show that no response appears, and one cycle after, to show that the held request is accepted.

// File: rtl/sac_pkg.sv
package sac_pkg;
    typedef enum logic {
        ST_IDLE       = 1'b0,
        ST_AGE_UPDATE = 1'b1
    } sac_state_e;
endpackage

// File: rtl/sac_match.sv
module sac_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       row_valid,
    input  logic [WAYS*TAG_W-1:0] row_tag,
    input  logic [WAYS*AGE_W-1:0] row_age,
    input  logic [TAG_W-1:0]      cmp_tag,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic [AGE_W-1:0]      hit_age,
    output logic                  any_free,
    output logic [WAY_W-1:0]      free_way
);
    logic [WAYS-1:0] match_vec;

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_cmp
            assign match_vec[g] = row_valid[g] && (row_tag[g*TAG_W +: TAG_W] == cmp_tag);
        end
    endgenerate

    // lowest-index priority encoders for the matching way and the free way
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!row_valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        hit_age = row_age[hit_way*AGE_W +: AGE_W];
    end
endmodule

// File: rtl/sac_victim.sv
module sac_victim #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic [WAYS*AGE_W-1:0] row_age,
    output logic [WAY_W-1:0]      victim_way,
    output logic [AGE_W-1:0]      victim_age
);
    localparam int NODES = 2 * WAYS - 1;

    logic [AGE_W-1:0] node_age [NODES];
    logic [WAY_W-1:0] node_way [NODES];

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_leaf
            assign node_age[WAYS-1+g] = row_age[g*AGE_W +: AGE_W];
            assign node_way[WAYS-1+g] = WAY_W'(g);
        end
        // heap layout: left child covers the lower way indices, so it wins ties
        for (genvar n = 0; n < WAYS - 1; n++) begin : g_node
            logic take_left;
            assign take_left   = node_age[2*n+1] >= node_age[2*n+2];
            assign node_age[n] = take_left ? node_age[2*n+1] : node_age[2*n+2];
            assign node_way[n] = take_left ? node_way[2*n+1] : node_way[2*n+2];
        end
    endgenerate

    assign victim_way = node_way[0];
    assign victim_age = node_age[0];
endmodule

// File: rtl/sac_age_next.sv
module sac_age_next #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       row_valid,
    input  logic [WAYS*AGE_W-1:0] age_cur,
    input  logic [WAY_W-1:0]      sel_way,
    input  logic                  promote,
    input  logic [AGE_W-1:0]      thr_age,
    output logic [WAYS*AGE_W-1:0] age_nxt
);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_rank
            logic [AGE_W-1:0] cur;
            logic             bump;
            assign cur = age_cur[g*AGE_W +: AGE_W];
            // promote: only ways younger than the chosen one age; fill: all valid ways age
            assign bump = promote ? (row_valid[g] && (cur < thr_age)) : row_valid[g];
            always_comb begin
                if (sel_way == WAY_W'(g)) begin
                    age_nxt[g*AGE_W +: AGE_W] = '0;
                end else if (bump && (cur != AGE_MAX)) begin
                    age_nxt[g*AGE_W +: AGE_W] = cur + 1'b1;
                end else begin
                    age_nxt[g*AGE_W +: AGE_W] = cur;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sa_age_cache.sv
module sa_age_cache
    import sac_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [$clog2(SETS)-1:0]   req_set,
    input  logic [TAG_W-1:0]          req_tag,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      busy,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [DATA_W-1:0]         rsp_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int AGE_W = $clog2(WAYS);
    localparam int WAY_W = $clog2(WAYS);

    // storage
    logic              valid_q [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS];
    logic [AGE_W-1:0]  age_q   [SETS][WAYS];

    sac_state_e state_q, state_d;

    logic [IDX_W-1:0] pend_set;
    logic [WAY_W-1:0] pend_way;
    logic [AGE_W-1:0] pend_age;

    logic                  accept;
    logic [IDX_W-1:0]      row_set;
    logic [WAYS-1:0]       row_valid;
    logic [WAYS*TAG_W-1:0] row_tag;
    logic [WAYS*AGE_W-1:0] row_age;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [AGE_W-1:0] hit_age;
    logic             any_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] victim_way;
    logic [AGE_W-1:0] victim_age;

    logic                  upd_promote;
    logic [WAY_W-1:0]      upd_way;
    logic [AGE_W-1:0]      upd_thr;
    logic [WAYS*AGE_W-1:0] age_nxt;
    logic [WAY_W-1:0]      fill_way;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign busy    = (state_q == ST_AGE_UPDATE);
    assign row_set = (state_q == ST_AGE_UPDATE) ? pend_set : req_set;

    // gather the addressed set into flat vectors
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_valid[w]                 = valid_q[row_set][w];
            row_tag[w*TAG_W +: TAG_W]    = tag_q[row_set][w];
            row_age[w*AGE_W +: AGE_W]    = age_q[row_set][w];
        end
    end

    sac_match #(
        .WAYS (WAYS),
        .TAG_W(TAG_W),
        .AGE_W(AGE_W),
        .WAY_W(WAY_W)
    ) u_match (
        .row_valid(row_valid),
        .row_tag  (row_tag),
        .row_age  (row_age),
        .cmp_tag  (req_tag),
        .hit      (hit),
        .hit_way  (hit_way),
        .hit_age  (hit_age),
        .any_free (any_free),
        .free_way (free_way)
    );

    sac_victim #(
        .WAYS (WAYS),
        .AGE_W(AGE_W),
        .WAY_W(WAY_W)
    ) u_victim (
        .row_age   (row_age),
        .victim_way(victim_way),
        .victim_age(victim_age)
    );

    assign fill_way = any_free ? free_way : victim_way;

    // rank update: AGE_UPDATE promotes the saved hit way; a write miss fills or evicts
    always_comb begin
        if (state_q == ST_AGE_UPDATE) begin
            upd_promote = 1'b1;
            upd_way     = pend_way;
            upd_thr     = pend_age;
        end else begin
            upd_promote = !any_free;
            upd_way     = fill_way;
            upd_thr     = victim_age;
        end
    end

    sac_age_next #(
        .WAYS (WAYS),
        .AGE_W(AGE_W),
        .WAY_W(WAY_W)
    ) u_age (
        .row_valid(row_valid),
        .age_cur  (row_age),
        .sel_way  (upd_way),
        .promote  (upd_promote),
        .thr_age  (upd_thr),
        .age_nxt  (age_nxt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && hit) begin
                    state_d = ST_AGE_UPDATE;
                end
            end
            ST_AGE_UPDATE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // pending hit bookkeeping for the rank rewrite
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_set <= '0;
            pend_way <= '0;
            pend_age <= '0;
        end else if (accept && hit) begin
            pend_set <= req_set;
            pend_way <= hit_way;
            pend_age <= hit_age;
        end
    end

    // array writes
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    age_q[s][w]   <= '0;
                end
            end
        end else if (state_q == ST_AGE_UPDATE) begin
            for (int w = 0; w < WAYS; w++) begin
                age_q[pend_set][w] <= age_nxt[w*AGE_W +: AGE_W];
            end
        end else if (accept && req_write) begin
            if (hit) begin
                data_q[req_set][hit_way] <= req_wdata;
            end else begin
                valid_q[req_set][fill_way] <= 1'b1;
                tag_q[req_set][fill_way]   <= req_tag;
                data_q[req_set][fill_way]  <= req_wdata;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[req_set][w] <= age_nxt[w*AGE_W +: AGE_W];
                end
            end
        end
    end

    // registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && hit;
            if (!accept) begin
                rsp_data <= '0;
            end else if (req_write) begin
                rsp_data <= req_wdata;
            end else if (hit) begin
                rsp_data <= data_q[req_set][hit_way];
            end else begin
                rsp_data <= '0;
            end
        end
    end
endmodule

// File: rtl/sac_checker.sv
module sac_checker (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic rsp_valid,
    input logic rsp_hit
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !rsp_valid));

    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> rsp_valid);

    // R3
    hit_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> busy);

    // R3
    busy_single_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R8
    miss_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> !busy);

    // R9
    stall_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> !rsp_valid);
endmodule

bind sa_age_cache sac_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .busy     (busy),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit)
);

// File: tb/tb_sa_age_cache.sv
module tb_sa_age_cache;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_set = '0;
    logic [7:0]  req_tag = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, rsp_valid, rsp_hit;
    logic [15:0] rsp_data;

    int n_chk = 0;
    int n_fail = 0;

    sa_age_cache dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_set(req_set), .req_tag(req_tag), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // {write, set, tag, wdata, exp_hit, exp_data}
    localparam logic [43:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 8'h10, 16'h0000, 1'b0, 16'h0000}, // R1 empty after reset
        {1'b1, 2'd0, 8'h10, 16'h1111, 1'b0, 16'h1111}, // R4 fill
        {1'b1, 2'd0, 8'h11, 16'h2222, 1'b0, 16'h2222}, // R4
        {1'b1, 2'd0, 8'h12, 16'h3333, 1'b0, 16'h3333}, // R4
        {1'b1, 2'd0, 8'h13, 16'h4444, 1'b0, 16'h4444}, // R4 set now full
        {1'b0, 2'd0, 8'h10, 16'h0000, 1'b1, 16'h1111}, // R2 R7 hit oldest
        {1'b0, 2'd0, 8'h99, 16'h0000, 1'b0, 16'h0000}, // R8 miss
        {1'b1, 2'd0, 8'h14, 16'h5555, 1'b0, 16'h5555}, // R6 evicts 11
        {1'b0, 2'd0, 8'h11, 16'h0000, 1'b0, 16'h0000}, // R6 R8 11 gone
        {1'b0, 2'd0, 8'h12, 16'h0000, 1'b1, 16'h3333}, // R7
        {1'b1, 2'd0, 8'h10, 16'h6666, 1'b1, 16'h6666}, // R5 in place
        {1'b0, 2'd0, 8'h10, 16'h0000, 1'b1, 16'h6666}, // R5 new data
        {1'b1, 2'd0, 8'h15, 16'h7777, 1'b0, 16'h7777}, // R6 R5 evicts 13
        {1'b0, 2'd0, 8'h13, 16'h0000, 1'b0, 16'h0000}, // R6
        {1'b0, 2'd0, 8'h14, 16'h0000, 1'b1, 16'h5555}, // R7
        {1'b1, 2'd0, 8'h16, 16'h8888, 1'b0, 16'h8888}, // R6 R7 evicts 12
        {1'b0, 2'd0, 8'h12, 16'h0000, 1'b0, 16'h0000}, // R6
        {1'b0, 2'd0, 8'h10, 16'h0000, 1'b1, 16'h6666}, // R2
        {1'b1, 2'd1, 8'h10, 16'h9999, 1'b0, 16'h9999}, // R10 other set
        {1'b0, 2'd1, 8'h10, 16'h0000, 1'b1, 16'h9999}, // R10
        {1'b0, 2'd0, 8'h10, 16'h0000, 1'b1, 16'h6666}, // R10 set 0 intact
        {1'b0, 2'd1, 8'h11, 16'h0000, 1'b0, 16'h0000}, // R10
        {1'b1, 2'd0, 8'h17, 16'h1234, 1'b0, 16'h1234}, // R6 evicts 15
        {1'b0, 2'd0, 8'h15, 16'h0000, 1'b0, 16'h0000}, // R6
        {1'b0, 2'd0, 8'h16, 16'h0000, 1'b1, 16'h8888}  // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic w, input logic [1:0] s, input logic [7:0] t,
                          input logic [15:0] d);
        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_set   = s;
        req_tag   = t;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic        vw, vh;
            logic [1:0]  vs;
            logic [7:0]  vt;
            logic [15:0] vd, ve;
            {vw, vs, vt, vd, vh, ve} = VEC[i];
            do_req(vw, vs, vt, vd);
            chk("R2 rsp_valid", 32'(rsp_valid), 32'd1);
            chk(vw ? "R4 R5 rsp_hit" : "R2 rsp_hit", 32'(rsp_hit), 32'(vh));
            chk(vw ? "R4 R5 rsp_data" : "R2 rsp_data", 32'(rsp_data), 32'(ve));
            chk("R3 busy with response", 32'(busy), 32'(vh));
            @(negedge clk);
            chk("R3 busy one cycle", 32'(busy), 32'd0);
        end

        // R9 stall: request held during the busy cycle
        do_req(1'b0, 2'd0, 8'h10, 16'h0);
        chk("R9 hit raises busy", 32'(busy), 32'd1);
        req_valid = 1'b1; req_write = 1'b0; req_set = 2'd0; req_tag = 8'h16;
        @(negedge clk);
        chk("R9 no response while stalled", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 held request accepted", 32'(rsp_valid), 32'd1);
        chk("R9 held request data", 32'(rsp_data), 32'h8888);
        @(negedge clk);

        // R1 reset mid-run wipes contents
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after second reset", 32'(busy), 32'd0);
        chk("R1 rsp_valid after second reset", 32'(rsp_valid), 32'd0);
        do_req(1'b0, 2'd0, 8'h10, 16'h0);
        chk("R1 entry cleared set0", 32'(rsp_hit), 32'd0);
        do_req(1'b0, 2'd1, 8'h10, 16'h0);
        chk("R1 entry cleared set1", 32'(rsp_hit), 32'd0);
        chk("R1 miss data zero", 32'(rsp_data), 32'd0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule